// File: doc/BRIEF.md
# Opcode-Fetch-Refreshed DRAM Controller

This block drives a multiplexed-address DRAM (row and column sharing ten address pins) from an 8-bit multiplexed CPU bus. It watches the address-latch strobe, the read and write strobes and the bus status pins, and it produces active-low row and column strobes, the row/column address select and the ten-bit DRAM address. It runs from a clock at twice the CPU clock. This gives the sequencer half-CPU-cycle resolution and leaves more of each bus cycle for the memory access itself.

The block has no refresh timer. Each opcode fetch starts exactly one refresh. When the fetch reads from some other memory, the controller issues a column-before-row refresh after the read strobe ends. When the fetch reads from the DRAM, the read access is extended: the row strobe is released and then reasserted while the column strobe stays low (a hidden refresh). A refresh row counter advances once for each refresh that completes, and its value is shown on the DRAM address pins while a refresh runs. A high address-latch strobe always aborts any activity. No refresh occurs while the CPU is halted.

All pins are plain control and status signals. No port carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `fetch_refresh_dram_ctrl`

## Requirements
- R1: Any clock edge that samples `ale` high leaves `ras_n`=1, `cas_n`=1 and `mux_col`=0 after that edge, and this aborts any access or refresh in progress.
- R2: A cycle counts as an opcode fetch only when `io_m`=0, `s1`=1 and `s0`=1 while `ale` is high. `dram_sel` is captured while `ale` is high as well. Any other status, including `io_m`=1 with `s1`=`s0`=1, never causes a refresh.
- R3: With `ale` low in a DRAM cycle, the edge that first samples `rd_n` or `wr_n` low drives `ras_n` low. The next edge sets `mux_col`=1 and the edge after that drives `cas_n` low. Both strobes stay low until an edge samples both bus strobes high. For a non-fetch cycle, that edge returns all three outputs to idle.
- R4: While `mux_col`=0 in an access, `dram_addr` = `addr[9:0]` (the row). While `mux_col`=1, `dram_addr` = `addr[19:10]` (the column).
- R5: Writes use exactly the read strobe timing. `dram_we_n` is `wr_n` delayed by one clock.
- R6: `dram_oe` is 1 only while `rd_n`=0 and `cas_n`=0.
- R7: On a fetch from non-DRAM memory, nothing happens while `rd_n` is low. The edge that samples `rd_n` high drives `cas_n` low with `ras_n` high. The next edge also drives `ras_n` low, both stay low for 2 clocks, and then both return high. `mux_col` stays 0 throughout.
- R8: On a fetch from the DRAM, the edge that samples `rd_n` high raises `ras_n` while `cas_n` stays low, for 2 clocks. `ras_n` then goes low again for 2 clocks with `cas_n` still low, and then both return high.
- R9: Every refresh fall of `ras_n` (a fall with `cas_n` low) follows at least 2 clocks of `ras_n` high.
- R10: At most one access or refresh occurs per bus cycle. A second strobe pulse before the next `ale` is ignored. Cycles that are neither DRAM nor fetch, and long stretches with no bus cycle (halt), produce no strobe activity.
- R11: During a refresh, `dram_addr` shows the refresh row counter. The counter advances by one for each refresh that completes, and a refresh aborted by `ale` does not advance it.
- R12: After reset: `ras_n`=1, `cas_n`=1, `mux_col`=0, `dram_we_n`=1, `dram_oe`=0, and the refresh row counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe, high at the start of each bus cycle |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| io_m | input | 1 | Bus status: 1 for I/O cycles, 0 for memory |
| s1 | input | 1 | Bus status bit 1 |
| s0 | input | 1 | Bus status bit 0 |
| dram_sel | input | 1 | Address decode: 1 when the cycle targets the DRAM |
| addr | input | 20 | Latched CPU address |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| mux_col | output | 1 | Address select: 0 row, 1 column |
| dram_addr | output | 10 | Multiplexed DRAM address |
| dram_we_n | output | 1 | DRAM write enable, active low |
| dram_oe | output | 1 | DRAM data enable toward the CPU |

## Verification
The sequencer is exercised with five bus cycle kinds, one per cycle: DRAM read, DRAM write, DRAM opcode fetch, non-DRAM opcode fetch, and a non-fetch status (including the interrupt-acknowledge-like code on the I/O side). Read and write separate the shared strobe timing from the write-enable and data-enable paths. The two fetch kinds separate the column-before-row refresh from the hidden refresh. The non-fetch status shows that only the exact fetch code triggers refresh. Aborts caused by the address-latch strobe, in the middle of an access and in the middle of a hidden refresh, followed by a later refresh whose address is checked, tell a counted refresh from an abandoned one. A second strobe pulse inside one bus cycle and a long halt-like idle stretch confirm that no extra RAS activity occurs.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT_RAS,
    ST_ACT_MUX,
    ST_ACT_CAS,
    ST_HID_PRE,
    ST_HID_RAS,
    ST_CBR_WAIT,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_WAIT_ALE
  } dramc_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramc_cycle_class.sv
module dramc_cycle_class (
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic io_m,
  input  logic s1,
  input  logic s0,
  input  logic dram_sel,
  input  logic wr_n,
  output logic is_fetch,
  output logic is_dram,
  output logic dram_we_n
);

  // Status and decode are captured for as long as the latch strobe is high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_fetch  <= 1'b0;
      is_dram   <= 1'b0;
      dram_we_n <= 1'b1;
    end else begin
      if (ale) begin
        is_fetch <= !io_m && s1 && s0;
        is_dram  <= dram_sel;
      end
      dram_we_n <= wr_n;
    end
  end

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int unsigned PRE_CYC     = 2,
  parameter int unsigned REF_RAS_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic rd_n,
  input  logic wr_n,
  input  logic is_fetch,
  input  logic is_dram,
  output logic ras_n,
  output logic cas_n,
  output logic mux_col,
  output logic ref_active,
  output logic ref_done
);

  localparam int unsigned HOLD_MAX = max_u(PRE_CYC, REF_RAS_CYC);
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);

  dramc_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic strobe;
  logic pre_last, ref_last;

  assign strobe   = !rd_n || !wr_n;
  assign pre_last = (cnt_q == CNT_W'(PRE_CYC - 1));
  assign ref_last = (cnt_q == CNT_W'(REF_RAS_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (strobe && is_dram)                 state_d = ST_ACT_RAS;
        else if (!rd_n && is_fetch && !is_dram) state_d = ST_CBR_WAIT;
      end
      ST_ACT_RAS:  state_d = ST_ACT_MUX;
      ST_ACT_MUX:  state_d = ST_ACT_CAS;
      ST_ACT_CAS:  if (!strobe) state_d = is_fetch ? ST_HID_PRE : ST_WAIT_ALE;
      ST_HID_PRE:  if (pre_last) state_d = ST_HID_RAS;
      ST_HID_RAS:  if (ref_last) state_d = ST_WAIT_ALE;
      ST_CBR_WAIT: if (rd_n) state_d = ST_CBR_CAS;
      ST_CBR_CAS:  state_d = ST_CBR_RAS;
      ST_CBR_RAS:  if (ref_last) state_d = ST_WAIT_ALE;
      ST_WAIT_ALE: state_d = ST_WAIT_ALE;
      default:     state_d = ST_IDLE;
    endcase
    if (ale) state_d = ST_IDLE;
    cnt_d = (state_d != state_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    ras_n      = !(state_q inside {ST_ACT_RAS, ST_ACT_MUX, ST_ACT_CAS, ST_HID_RAS, ST_CBR_RAS});
    cas_n      = !(state_q inside {ST_ACT_CAS, ST_HID_PRE, ST_HID_RAS, ST_CBR_CAS, ST_CBR_RAS});
    mux_col    = state_q inside {ST_ACT_MUX, ST_ACT_CAS};
    ref_active = state_q inside {ST_HID_PRE, ST_HID_RAS, ST_CBR_CAS, ST_CBR_RAS};
  end

  assign ref_done = (state_q inside {ST_HID_RAS, ST_CBR_RAS}) && ref_last && !ale;

  // Precharge tracker for the refresh-spacing check.
  logic [CNT_W-1:0] ras_hi_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                             ras_hi_q <= CNT_W'(PRE_CYC);
    else if (!ras_n)                        ras_hi_q <= '0;
    else if (ras_hi_q != CNT_W'(PRE_CYC))  ras_hi_q <= ras_hi_q + 1'b1;
  end

  assert_ale_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ale) |-> (ras_n && cas_n && !mux_col));

  assert_mux_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_col) |-> (!ras_n && !$past(ras_n)));

  assert_cas_after_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ref_active) |-> (mux_col && $past(mux_col)));

  assert_cas_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  assert_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (32'(ras_hi_q) >= PRE_CYC));

endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned ROW_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mux_col,
  input  logic              ras_n,
  input  logic              ref_active,
  input  logic              ref_done,
  output logic [ROW_W-1:0]  dram_addr
);

  localparam int unsigned COL_W = ADDR_W - ROW_W;

  logic [ROW_W-1:0] ref_row_q;
  logic [ROW_W-1:0] row_part, col_part;

  assign row_part = addr[ROW_W-1:0];

  generate
    if (COL_W >= ROW_W) begin : g_col_full
      assign col_part = addr[ROW_W +: ROW_W];
    end else begin : g_col_pad
      assign col_part = {{(ROW_W-COL_W){1'b0}}, addr[ADDR_W-1:ROW_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        ref_row_q <= '0;
    else if (ref_done) ref_row_q <= ref_row_q + 1'b1;
  end

  always_comb begin
    if (ref_active)   dram_addr = ref_row_q;
    else if (mux_col) dram_addr = col_part;
    else              dram_addr = row_part;
  end

  assert_col_in_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mux_col |-> !ras_n);

endmodule

// File: rtl/fetch_refresh_dram_ctrl.sv
module fetch_refresh_dram_ctrl #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned ROW_W       = 10,
  parameter int unsigned PRE_CYC     = 2,
  parameter int unsigned REF_RAS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              io_m,
  input  logic              s1,
  input  logic              s0,
  input  logic              dram_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              mux_col,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              dram_we_n,
  output logic              dram_oe
);

  logic is_fetch, is_dram, ref_active, ref_done;

  dramc_cycle_class u_class (
    .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
    .dram_sel(dram_sel), .wr_n(wr_n),
    .is_fetch(is_fetch), .is_dram(is_dram), .dram_we_n(dram_we_n)
  );

  dramc_seq #(.PRE_CYC(PRE_CYC), .REF_RAS_CYC(REF_RAS_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .is_fetch(is_fetch), .is_dram(is_dram),
    .ras_n(ras_n), .cas_n(cas_n), .mux_col(mux_col),
    .ref_active(ref_active), .ref_done(ref_done)
  );

  dramc_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mux_col(mux_col), .ras_n(ras_n),
    .ref_active(ref_active), .ref_done(ref_done), .dram_addr(dram_addr)
  );

  assign dram_oe = !rd_n && !cas_n;

endmodule

// File: tb/test_fetch_refresh_dram_ctrl.sv
module test_fetch_refresh_dram_ctrl;

  logic clk = 1'b0;
  logic rst_n, ale, rd_n, wr_n, io_m, s1, s0, dram_sel;
  logic [19:0] addr;
  logic ras_n, cas_n, mux_col, dram_we_n, dram_oe;
  logic [9:0] dram_addr;

  int checks = 0;
  int failures = 0;
  logic [9:0] exp_ref = '0;

  always #5 clk = !clk;

  fetch_refresh_dram_ctrl i_fetch_refresh_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .dram_sel(dram_sel), .addr(addr),
    .ras_n(ras_n), .cas_n(cas_n), .mux_col(mux_col), .dram_addr(dram_addr),
    .dram_we_n(dram_we_n), .dram_oe(dram_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req, input logic r, input logic c, input logic m);
    chk(req, {29'd0, ras_n, cas_n, mux_col}, {29'd0, r, c, m});
  endtask

  task automatic step(input logic a, input logic rdn, input logic wrn);
    @(negedge clk);
    ale = a; rd_n = rdn; wr_n = wrn;
    @(posedge clk);
    #3;
  endtask

  task automatic open_cycle(input logic m, input logic st1, input logic st0, input logic sel);
    @(negedge clk);
    io_m = m; s1 = st1; s0 = st0; dram_sel = sel;
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R1 idle after latch strobe", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_read;
    open_cycle(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R3 read ras", 1'b0, 1'b1, 1'b0);
    chk("R4 row", 32'(dram_addr), 32'(addr[9:0]));
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R3 read mux", 1'b0, 1'b1, 1'b1);
    chk("R4 col", 32'(dram_addr), 32'(addr[19:10]));
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R3 read cas", 1'b0, 1'b0, 1'b1);
    chk("R6 oe on read", 32'(dram_oe), 32'd1);
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R3 read hold", 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R3 read end", 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R10 second pulse ignored", 1'b1, 1'b1, 1'b0);
    chk("R6 oe without cas", 32'(dram_oe), 32'd0);
    step(1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_write;
    open_cycle(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    chk_pins("R5 write ras", 1'b0, 1'b1, 1'b0);
    chk("R5 we delayed", 32'(dram_we_n), 32'd0);
    step(1'b0, 1'b1, 1'b0);
    chk_pins("R5 write mux", 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    chk_pins("R5 write cas", 1'b0, 1'b0, 1'b1);
    chk("R6 no oe on write", 32'(dram_oe), 32'd0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R5 write end", 1'b1, 1'b1, 1'b0);
    chk("R5 we released", 32'(dram_we_n), 32'd1);
  endtask

  task automatic t_hidden;
    open_cycle(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R3 fetch cas", 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R8 ras up cas low", 1'b1, 1'b0, 1'b0);
    chk("R11 hidden refresh row", 32'(dram_addr), 32'(exp_ref));
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R8 precharge 2", 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R8 ras again", 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R8 ras hold", 1'b0, 1'b0, 1'b0);
    chk("R6 no oe in refresh", 32'(dram_oe), 32'd0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R8 end", 1'b1, 1'b1, 1'b0);
    exp_ref++;
  endtask

  task automatic t_cbr;
    open_cycle(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R7 quiet during read", 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk_pins("R7 quiet during read", 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R7 cas first", 1'b1, 1'b0, 1'b0);
    chk("R11 cbr refresh row", 32'(dram_addr), 32'(exp_ref));
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R7 ras second", 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R7 hold", 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk_pins("R7 end", 1'b1, 1'b1, 1'b0);
    exp_ref++;
  endtask

  task automatic t_no_fetch;
    open_cycle(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, (i < 3) ? 1'b0 : 1'b1, 1'b1);
      chk_pins("R2 io status no refresh", 1'b1, 1'b1, 1'b0);
    end
    open_cycle(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, (i < 3) ? 1'b0 : 1'b1, 1'b1);
      chk_pins("R10 foreign read quiet", 1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic t_abort;
    open_cycle(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk_pins("R1 abort access", 1'b1, 1'b1, 1'b0);
    open_cycle(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk_pins("R1 abort hidden refresh", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_halt;
    @(negedge clk);
    dram_sel = 1'b1; io_m = 1'b0; s1 = 1'b1; s0 = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 1'b1, 1'b1);
      chk_pins("R10 halt no refresh", 1'b1, 1'b1, 1'b0);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    io_m = 1'b0; s1 = 1'b0; s0 = 1'b0; dram_sel = 1'b0;
    addr = 20'hA53C7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #3;
    chk_pins("R12 reset strobes", 1'b1, 1'b1, 1'b0);
    chk("R12 reset we", 32'(dram_we_n), 32'd1);
    chk("R12 reset oe", 32'(dram_oe), 32'd0);
    t_cbr;
    t_read;
    t_write;
    addr = 20'h3C00F;
    t_read;
    t_hidden;
    t_no_fetch;
    t_cbr;
    t_abort;
    t_hidden;
    t_halt;
    t_cbr;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule